// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block turns a (process ID, virtual page number, page offset) request into a physical address by searching an inverted translation table. The table holds one entry per physical frame, and the frame number is not stored anywhere: the position of an entry in the table is the frame it describes. Each entry carries a valid flag, the owning process ID, the virtual page number mapped into that frame, and a link to the next entry on the same hash chain. Because the table is indexed by frame rather than by page, all processes share it, and an entry only matches when both its process ID and its page number equal the request.

A lookup starts at a slot picked by hashing the process ID and page number together. It then visits one entry per clock, following the links, until an entry matches or the chain ends. A match returns the entry's index joined with the page offset. A page fault is returned if the chain ends, if a visited entry is not valid, or if a step limit is reached (so a chain that loops back on itself still gives an answer). The table is loaded through a plain write port. The allocation of chains and the replacement policy belong to the software that drives that port.

Requests arrive on a valid/ready channel, and results leave on another. The block takes one request at a time. It lowers `req_ready` from the moment it accepts a request until its result has been taken. A result is presented with `rsp_valid` and held, with all of its fields unchanged, for as long as `rsp_ready` stays low. The block drops the result and becomes ready again on the first clock edge where `rsp_valid` and `rsp_ready` are both high.

Top module: `ipt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every table entry is invalid, so the first lookup faults after examining a single entry.
- R2: The first slot examined is the 6-bit value obtained by zero-extending the 8-bit process ID to 20 bits, XORing it with the 20-bit page number, and XORing together the chunks at bits [5:0], [11:6], [17:12] and [19:18] (the last zero-extended).
- R3: An entry matches when it is valid and both its process ID and its page number equal the request. On a match `rsp_fault` is 0 and `rsp_paddr` is {entry index (6 bits), page offset (12 bits)}.
- R4: The next-link field is 7 bits wide. A value with bit 6 set is the null link and ends the chain. Reaching a non-matching entry whose link is null gives a fault, and any other link value names the next slot to examine through its low 6 bits.
- R5: Visiting an entry whose valid flag is 0, whether at the hashed slot or further down a chain, gives a fault at once.
- R6: Exactly one entry is examined per clock. If the lookup ends at the k-th entry examined, `rsp_valid` rises k clock edges after the edge that accepted the request.
- R7: No more than 64 entries are examined. A lookup that has examined 64 entries without a match faults, with a latency of 64. A match found on the 64th entry is still reported as a hit.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay unchanged. `req_ready` stays 0 from acceptance until the response handshake.
- R9: A write through the write port on one clock edge replaces all fields of the addressed entry, and a lookup accepted on a later edge sees the new contents.
- R10: An entry with the requested page number but a different process ID does not match, and the walk goes on down its chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_pid | input | 8 | Process ID of the request |
| req_vpn | input | 20 | Virtual page number of the request |
| req_off | input | 12 | Page offset carried into the result |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | 1 means page fault; address is then meaningless |
| rsp_paddr | output | 18 | Physical address {frame, offset} |
| wr_en | input | 1 | Write one table entry this clock |
| wr_idx | input | 6 | Frame index of the entry to write |
| wr_vld | input | 1 | Valid flag to store |
| wr_pid | input | 8 | Process ID to store |
| wr_vpn | input | 20 | Page number to store |
| wr_nxt | input | 7 | Next link to store; bit 6 set means null |

## Verification
The lookup latency equals the number of entries examined, counted in clock edges from the accepting edge, so the bench knows the chain it built and predicts the exact edge count for each lookup. Checks count edges after acceptance and sample in the following low clock phase. They compare that count with the prediction, from 1 for a hashed-slot decision up to 64 for a full-length chain or a loop. Table writes complete one edge before the next request is raised. Results held under back-pressure are re-sampled in every low phase while `rsp_ready` stays low.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W = 8,
  parameter int VPN_W = 20,
  parameter int IDX_W = 6
) (
  input  logic [PID_W-1:0] pid,
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] slot
);
  localparam int KEY_W  = (PID_W > VPN_W) ? PID_W : VPN_W;
  localparam int NCHUNK = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int FOLD_W = NCHUNK * IDX_W;

  logic [FOLD_W-1:0] folded_src;
  logic [IDX_W-1:0]  chunk [NCHUNK];

  always_comb begin
    folded_src = '0;
    folded_src[PID_W-1:0] = pid;
    folded_src[VPN_W-1:0] = folded_src[VPN_W-1:0] ^ vpn;
  end

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign chunk[c] = folded_src[c*IDX_W +: IDX_W];
  end

  always_comb begin
    slot = '0;
    for (int c = 0; c < NCHUNK; c++) slot = slot ^ chunk[c];
  end
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int FRAMES = 64,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20,
  parameter int IDX_W  = $clog2(FRAMES),
  parameter int NXT_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [NXT_W-1:0] wr_nxt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [PID_W-1:0] rd_pid,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [NXT_W-1:0] rd_nxt
);
  logic             vld_q [FRAMES];
  logic [PID_W-1:0] pid_q [FRAMES];
  logic [VPN_W-1:0] vpn_q [FRAMES];
  logic [NXT_W-1:0] nxt_q [FRAMES];

  for (genvar e = 0; e < FRAMES; e++) begin : g_entry
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
        pid_q[e] <= '0;
        vpn_q[e] <= '0;
        nxt_q[e] <= '1;
      end else if (hit_wr) begin
        vld_q[e] <= wr_vld;
        pid_q[e] <= wr_pid;
        vpn_q[e] <= wr_vpn;
        nxt_q[e] <= wr_nxt;
      end
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_pid = pid_q[rd_idx];
  assign rd_vpn = vpn_q[rd_idx];
  assign rd_nxt = nxt_q[rd_idx];
endmodule

// File: rtl/ipt_walk.sv
module ipt_walk
  import ipt_pkg::*;
#(
  parameter int FRAMES = 64,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = $clog2(FRAMES),
  parameter int NXT_W  = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [IDX_W-1:0]       start_slot,
  output logic [PID_W-1:0]       key_pid,
  output logic [VPN_W-1:0]       key_vpn,
  output logic [IDX_W-1:0]       cur_idx,
  input  logic                   ent_vld,
  input  logic [PID_W-1:0]       ent_pid,
  input  logic [VPN_W-1:0]       ent_vpn,
  input  logic [NXT_W-1:0]       ent_nxt,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_fault,
  output logic [IDX_W+OFF_W-1:0] rsp_paddr
);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(FRAMES - 1);

  walk_st_e         st_q;
  logic [OFF_W-1:0] off_q;
  logic [IDX_W-1:0] steps_q;
  logic [IDX_W-1:0] frame_q;
  logic             fault_q;

  logic accept, ent_match, chain_end, give_up;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ent_match = ent_vld && (ent_pid == key_pid) && (ent_vpn == key_vpn);
  assign chain_end = ent_nxt[NXT_W-1];
  assign give_up   = !ent_vld || chain_end || (steps_q == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      key_pid <= '0;
      key_vpn <= '0;
      off_q   <= '0;
      cur_idx <= '0;
      steps_q <= '0;
      frame_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          key_pid <= req_pid;
          key_vpn <= req_vpn;
          off_q   <= req_off;
          cur_idx <= start_slot;
          steps_q <= '0;
          st_q    <= ST_WALK;
        end
        ST_WALK: begin
          if (ent_match) begin
            frame_q <= cur_idx;
            fault_q <= 1'b0;
            st_q    <= ST_RESP;
          end else if (give_up) begin
            frame_q <= '0;
            fault_q <= 1'b1;
            st_q    <= ST_RESP;
          end else begin
            cur_idx <= ent_nxt[IDX_W-1:0];
            steps_q <= steps_q + 1'b1;
          end
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_paddr = {frame_q, off_q};
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int FRAMES = 64,
  parameter int PID_W  = 8,
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = $clog2(FRAMES),
  parameter int NXT_W  = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_fault,
  output logic [IDX_W+OFF_W-1:0] rsp_paddr,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_vld,
  input  logic [PID_W-1:0]       wr_pid,
  input  logic [VPN_W-1:0]       wr_vpn,
  input  logic [NXT_W-1:0]       wr_nxt
);
  logic [IDX_W-1:0] start_slot, cur_idx;
  logic [PID_W-1:0] key_pid, ent_pid;
  logic [VPN_W-1:0] key_vpn, ent_vpn;
  logic [NXT_W-1:0] ent_nxt;
  logic             ent_vld;

  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .pid(req_pid), .vpn(req_vpn), .slot(start_slot)
  );

  ipt_table #(
    .FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W), .NXT_W(NXT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_nxt(wr_nxt),
    .rd_idx(cur_idx), .rd_vld(ent_vld), .rd_pid(ent_pid),
    .rd_vpn(ent_vpn), .rd_nxt(ent_nxt)
  );

  ipt_walk #(
    .FRAMES(FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .NXT_W(NXT_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
    .start_slot(start_slot),
    .key_pid(key_pid), .key_vpn(key_vpn), .cur_idx(cur_idx),
    .ent_vld(ent_vld), .ent_pid(ent_pid), .ent_vpn(ent_vpn), .ent_nxt(ent_nxt),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );
endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
  parameter int FRAMES  = 64,
  parameter int PADDR_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_fault,
  input logic [PADDR_W-1:0] rsp_paddr
);
  localparam int CNT_W = $clog2(FRAMES + 2) + 1;

  logic             busy_q;
  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= '0;
    end else if (req_valid && req_ready) begin
      busy_q <= 1'b1;
      wait_q <= '0;
    end else if (rsp_valid && rsp_ready) begin
      busy_q <= 1'b0;
    end else if (busy_q && !rsp_valid) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr))) // R8
    else $error("AST_RSP_HELD");
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !req_ready) // R8
    else $error("AST_NO_ACCEPT_BUSY");
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy_q) // R6
    else $error("AST_RSP_AFTER_REQ");
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (wait_q >= CNT_W'(1) && wait_q <= CNT_W'(FRAMES))) // R7
    else $error("AST_STEP_BOUND");
endmodule

bind ipt_walker ipt_walker_chk #(.FRAMES(FRAMES), .PADDR_W(IDX_W + OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr)
);

// File: tb/ipt_walker_tb.sv
`timescale 1ns/1ps
module ipt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [7:0]  req_pid = '0;
  logic [19:0] req_vpn = '0;
  logic [11:0] req_off = '0;
  logic [17:0] rsp_paddr;
  logic        wr_en = 1'b0, wr_vld = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [7:0]  wr_pid = '0;
  logic [19:0] wr_vpn = '0;
  logic [6:0]  wr_nxt = '1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipt_walker u_dut (.*);

  function automatic int bh(input int pid, input int vpn);
    int x;
    x = (pid & 255) ^ (vpn & 20'hFFFFF);
    return (x ^ (x >> 6) ^ (x >> 12) ^ (x >> 18)) & 63;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit v, input int pid, input int vpn, input int nxt);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_vld = v;
    wr_pid = 8'(pid); wr_vpn = 20'(vpn); wr_nxt = 7'(nxt);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input int pid, input int vpn, input int off,
                      input bit ef, input int efr, input int elat, input int hold);
    int n;
    logic [17:0] pa;
    logic f;
    @(negedge clk);
    req_pid = 8'(pid); req_vpn = 20'(vpn); req_off = 12'(off);
    req_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk({req, " latency"}, n, elat);
    chk({req, " fault"}, rsp_fault, ef);
    if (!ef) chk({req, " paddr"}, rsp_paddr, efr * 4096 + (off & 12'hFFF));
    pa = rsp_paddr; f = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R8 held valid", rsp_valid, 1);
      chk("R8 held paddr", rsp_paddr, pa);
      chk("R8 held fault", rsp_fault, f);
      chk("R8 busy not ready", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({req, " rsp dropped"}, rsp_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int h, pa_, pb_, v_, q;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no rsp after reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready idle", req_ready, 1);
    look("R1 empty table", 8'h33, 20'h12345, 12'h0AB, 1, 0, 1, 0);

    // R2 R3: sweep of single-entry chains at the hashed slot
    for (int f = 0; f < 64; f++) begin
      pa_ = (f * 37 + 5) & 255;
      v_  = (f * 40503 + 11) & 20'hFFFFF;
      h   = bh(pa_, v_);
      wr(h, 1, pa_, v_, 7'h7F);
      look("R2 R3 hashed hit", pa_, v_, f * 61, 0, h, 1, 0);
    end
    for (int e = 0; e < 64; e++) wr(e, 0, 0, 0, 7'h7F);

    // R6 R7: 64-long chain, match on the last entry
    pa_ = 8'h5A; v_ = 20'hABCDE; h = bh(pa_, v_);
    for (int i = 0; i < 63; i++) wr((h + i) % 64, 1, pa_, v_ ^ (i + 1), (h + i + 1) % 64);
    wr((h + 63) % 64, 1, pa_, v_, 7'h7F);
    look("R7 hit on 64th entry", pa_, v_, 12'h777, 0, (h + 63) % 64, 64, 0);
    // R7: close into a loop without match
    wr((h + 63) % 64, 1, pa_, v_ ^ 20'h80000, h);
    look("R7 loop limit fault", pa_, v_, 12'h001, 1, 0, 64, 0);
    // R5: invalid entry mid-chain
    wr((h + 1) % 64, 0, pa_, v_, (h + 2) % 64);
    look("R5 invalid mid chain", pa_, v_, 12'h002, 1, 0, 2, 0);
    // R4: null link with only bit 6 set
    wr(h, 1, pa_, v_ ^ 1, 7'h40);
    look("R4 null link end", pa_, v_, 12'h003, 1, 0, 1, 0);
    // R6 R8: three-step chain with back-pressure
    wr(h, 1, pa_, v_ ^ 1, (h + 1) % 64);
    wr((h + 1) % 64, 1, pa_, v_ ^ 2, (h + 2) % 64);
    wr((h + 2) % 64, 1, pa_, v_, 7'h7F);
    look("R6 three-step hit", pa_, v_, 12'hFED, 0, (h + 2) % 64, 3, 3);
    // R5: invalid hashed slot
    wr(h, 0, pa_, v_, (h + 1) % 64);
    look("R5 invalid hashed slot", pa_, v_, 12'h004, 1, 0, 1, 2);

    // R10: same page, different process, same hash
    for (int e = 0; e < 64; e++) wr(e, 0, 0, 0, 7'h7F);
    pa_ = 8'h12; pb_ = pa_ ^ 8'h41; v_ = 20'h00345;
    h = bh(pa_, v_);
    chk("R2 hash alias", bh(pb_, v_), h);
    q = (h + 5) % 64;
    wr(h, 1, pa_, v_, 7'h7F);
    look("R10 pid mismatch faults", pb_, v_, 12'h010, 1, 0, 1, 0);
    wr(h, 1, pa_, v_, q);
    wr(q, 1, pb_, v_, 7'h7F);
    look("R10 second process hit", pb_, v_, 12'h020, 0, q, 2, 0);
    look("R10 first process hit", pa_, v_, 12'h030, 0, h, 1, 0);
    // R9: overwrite then look up right away
    wr(h, 1, pa_, v_ ^ 1, 7'h7F);
    look("R9 overwrite seen", pa_, v_, 12'h040, 1, 0, 1, 0);
    wr(h, 1, pa_, v_, 7'h7F);
    look("R9 restore seen", pa_, v_, 12'h050, 0, h, 1, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule